// File: doc/BRIEF.md
# Next-PC Select and Wrong-Path Kill Unit

This unit steers the front end of a short in-order pipeline with no branch prediction and no delay slots. Each cycle it looks at the instruction held in the decode register and the one held in the execute register. It also takes the ALU zero flag and the hazard stall line. From these it decides where the next fetch address comes from: the sequential increment, an absolute jump target, a register-indirect target, or a conditional branch target. It also decides which stage registers get a bubble in place of the word they would have loaded, so that instructions fetched down the wrong path never take effect.

The decision is a fixed priority. A conditional branch resolved as taken in execute is the older instruction, so it overrides anything decode holds. A decode-stage jump comes next. Only when neither redirects does the stall line matter. A jump discovered in decode costs one killed instruction. A branch discovered in execute costs two. Whenever the path changes, killing the wrong-path word wins over stalling.

The wrapper holds the program counter and the two instruction registers, so the kill sequence can be seen cycle by cycle at the ports. It takes the three redirect targets as inputs, because they are computed by logic outside this unit.

Top module: `npc_kill_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `pc` equals the START parameter and both `ir_dec` and `ir_exe` are all zero.
- R2: The instruction class comes from the top six bits of the word. 0x02 is an absolute jump, 0x03 an absolute jump with link, 0x04 branch-if-zero, 0x05 branch-if-nonzero, 0x06 an indirect jump and 0x07 an indirect jump with link. Every other value is sequential. The all-zero word is the bubble.
- R3: When `ir_exe` holds branch-if-zero with `alu_zero`=1, or branch-if-nonzero with `alu_zero`=0, `pc_sel` is 3 and the next `pc` is `br_target`. This holds whatever decode holds and whatever `stall` is.
- R4: Otherwise, when `ir_dec` holds either absolute jump, `pc_sel` is 1 and the next `pc` is `jabs_target`.
- R5: Otherwise, when `ir_dec` holds either indirect jump, `pc_sel` is 2 and the next `pc` is `rind_target`.
- R6: Otherwise `pc_sel` is 0. The next `pc` is `pc`+STEP when `stall` is low, and `pc` is unchanged when `stall` is high.
- R7: `dec_sel` is 1 when R3 applies or `ir_dec` holds any jump, and `ir_dec` then loads zero. Otherwise `ir_dec` keeps its value under `stall`, or else loads `fetch_word`.
- R8: `exe_sel` is 1 when R3 applies or `stall` is high, and `ir_exe` then loads zero. Otherwise `ir_exe` loads `ir_dec`.
- R9: Without stalls, a jump reaching execute is followed there by exactly one bubble. A taken branch in execute is followed by exactly two bubbles. A not-taken branch is followed by no bubble.
- R10: When a redirect (R3 to R5) coincides with `stall`, the redirect still happens and `ir_dec` still loads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_word | input | IW | Word read from instruction memory at `pc` |
| stall | input | 1 | Hazard stall request |
| alu_zero | input | 1 | ALU zero flag for the instruction in execute |
| jabs_target | input | AW | Absolute jump target |
| rind_target | input | AW | Register-indirect jump target |
| br_target | input | AW | Conditional branch target |
| pc | output | AW | Current fetch address |
| ir_dec | output | IW | Decode-stage instruction register |
| ir_exe | output | IW | Execute-stage instruction register |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 absolute, 2 indirect, 3 branch |
| dec_sel | output | 1 | 1 when decode loads a bubble |
| exe_sel | output | 1 | 1 when execute loads a bubble |

## Verification
The bench builds the unit with its defaults: 32-bit addresses and words, START 0 and STEP 4. With these values the directed program's fixed addresses and the hashed random program line up exactly with the reference model's arithmetic. A directed loop with the stall line low drives jumps, taken and not-taken branches, and a jump sitting behind a taken branch through the pipe. The execute stream is then scanned to count bubbles. Long pseudo-random runs mix stalls with every redirect kind, which covers the stall-plus-redirect case and the branch-over-jump priority from many pipeline states.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPW = 6;

    localparam logic [OPW-1:0] OPC_JMP    = 6'h02;
    localparam logic [OPW-1:0] OPC_JMPL   = 6'h03;
    localparam logic [OPW-1:0] OPC_BRZ    = 6'h04;
    localparam logic [OPW-1:0] OPC_BRNZ   = 6'h05;
    localparam logic [OPW-1:0] OPC_JREG   = 6'h06;
    localparam logic [OPW-1:0] OPC_JREGL  = 6'h07;

    typedef enum logic [2:0] {
        CL_SEQ      = 3'd0,
        CL_JUMP_ABS = 3'd1,
        CL_JUMP_IND = 3'd2,
        CL_BR_ZERO  = 3'd3,
        CL_BR_NZ    = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_ABS = 2'd1,
        SRC_IND = 2'd2,
        SRC_BR  = 2'd3
    } pc_src_e;

endpackage

// File: rtl/op_classify.sv
module op_classify
    import npc_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0] word,
    output op_class_e     cls
);

    localparam int OP_LSB = IW - OPW;

    logic [OPW-1:0] opc;

    assign opc = word[IW-1:OP_LSB];

    // R2: opcode field occupies the top six bits
    always_comb begin
        unique case (opc)
            OPC_JMP, OPC_JMPL:   cls = CL_JUMP_ABS;
            OPC_JREG, OPC_JREGL: cls = CL_JUMP_IND;
            OPC_BRZ:             cls = CL_BR_ZERO;
            OPC_BRNZ:            cls = CL_BR_NZ;
            default:             cls = CL_SEQ;
        endcase
    end

endmodule

// File: rtl/redirect_ctrl.sv
module redirect_ctrl
    import npc_pkg::*;
(
    input  op_class_e cls_dec,
    input  op_class_e cls_exe,
    input  logic      zero,
    input  logic      stall,
    output pc_src_e   src,
    output logic      dec_nop,
    output logic      exe_nop
);

    logic br_taken;

    always_comb begin
        unique case (cls_exe)
            CL_BR_ZERO: br_taken = zero;
            CL_BR_NZ:   br_taken = !zero;
            default:    br_taken = 1'b0;
        endcase
    end

    // older instruction in execute first, then decode
    always_comb begin
        if (br_taken)
            src = SRC_BR;
        else if (cls_dec == CL_JUMP_ABS)
            src = SRC_ABS;
        else if (cls_dec == CL_JUMP_IND)
            src = SRC_IND;
        else
            src = SRC_SEQ;
    end

    // kill selects follow the chosen source; kill beats stall
    always_comb begin
        unique case (src)
            SRC_BR: begin
                dec_nop = 1'b1;
                exe_nop = 1'b1;
            end
            SRC_ABS, SRC_IND: begin
                dec_nop = 1'b1;
                exe_nop = stall;
            end
            default: begin
                dec_nop = 1'b0;
                exe_nop = stall;
            end
        endcase
    end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import npc_pkg::*;
#(
    parameter int            AW    = 32,
    parameter logic [AW-1:0] START = '0,
    parameter int            STEP  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_src_e       src,
    input  logic          stall,
    input  logic [AW-1:0] jabs_target,
    input  logic [AW-1:0] rind_target,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] pc_next;

    always_comb begin
        unique case (src)
            SRC_BR:  pc_next = br_target;
            SRC_ABS: pc_next = jabs_target;
            SRC_IND: pc_next = rind_target;
            default: pc_next = stall ? pc : pc + INC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= START;
        else
            pc <= pc_next;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && src == SRC_SEQ) |=> $stable(pc)); // R6

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && src == SRC_SEQ) |=> pc == $past(pc) + INC); // R6

endmodule

// File: rtl/ir_stages.sv
module ir_stages #(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] fetch_word,
    input  logic          stall,
    input  logic          dec_nop,
    input  logic          exe_nop,
    output logic [IW-1:0] ir_dec,
    output logic [IW-1:0] ir_exe
);

    localparam logic [IW-1:0] BUBBLE = '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_dec <= BUBBLE;
            ir_exe <= BUBBLE;
        end else begin
            if (dec_nop)
                ir_dec <= BUBBLE;
            else if (!stall)
                ir_dec <= fetch_word;
            ir_exe <= exe_nop ? BUBBLE : ir_dec;
        end
    end

    AST_DEC_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_nop |=> ir_dec == BUBBLE); // R7

    AST_EXE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        exe_nop |=> ir_exe == BUBBLE); // R8

    AST_EXE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !exe_nop |=> ir_exe == $past(ir_dec)); // R8

endmodule

// File: rtl/npc_kill_unit.sv
module npc_kill_unit
    import npc_pkg::*;
#(
    parameter int            AW    = 32,
    parameter int            IW    = 32,
    parameter logic [AW-1:0] START = '0,
    parameter int            STEP  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] fetch_word,
    input  logic          stall,
    input  logic          alu_zero,
    input  logic [AW-1:0] jabs_target,
    input  logic [AW-1:0] rind_target,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] pc,
    output logic [IW-1:0] ir_dec,
    output logic [IW-1:0] ir_exe,
    output logic [1:0]    pc_sel,
    output logic          dec_sel,
    output logic          exe_sel
);

    op_class_e cls_dec;
    op_class_e cls_exe;
    pc_src_e   src;
    logic      dec_nop;
    logic      exe_nop;

    op_classify #(.IW(IW)) u_cls_dec (.word(ir_dec), .cls(cls_dec));
    op_classify #(.IW(IW)) u_cls_exe (.word(ir_exe), .cls(cls_exe));

    redirect_ctrl u_ctrl (
        .cls_dec (cls_dec),
        .cls_exe (cls_exe),
        .zero    (alu_zero),
        .stall   (stall),
        .src     (src),
        .dec_nop (dec_nop),
        .exe_nop (exe_nop)
    );

    pc_unit #(.AW(AW), .START(START), .STEP(STEP)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (src),
        .stall       (stall),
        .jabs_target (jabs_target),
        .rind_target (rind_target),
        .br_target   (br_target),
        .pc          (pc)
    );

    ir_stages #(.IW(IW)) u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_word (fetch_word),
        .stall      (stall),
        .dec_nop    (dec_nop),
        .exe_nop    (exe_nop),
        .ir_dec     (ir_dec),
        .ir_exe     (ir_exe)
    );

    assign pc_sel  = src;
    assign dec_sel = dec_nop;
    assign exe_sel = exe_nop;

    AST_BR_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_BR) |=> pc == $past(br_target)); // R3

    AST_BR_TWO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_BR) |=> (ir_dec == '0 && ir_exe == '0)); // R9

    AST_ABS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_ABS) |=> pc == $past(jabs_target)); // R4

    AST_IND_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_IND) |=> pc == $past(rind_target)); // R5

    AST_KILL_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && src != SRC_SEQ) |=> ir_dec == '0); // R10

endmodule

// File: tb/npc_kill_unit_test.sv
module npc_kill_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word;
    logic        stall = 1'b0;
    logic        alu_zero = 1'b0;
    logic [31:0] jabs_target = '0;
    logic [31:0] rind_target = '0;
    logic [31:0] br_target = '0;
    logic [31:0] pc;
    logic [31:0] ir_dec;
    logic [31:0] ir_exe;
    logic [1:0]  pc_sel;
    logic        dec_sel;
    logic        exe_sel;

    int checks = 0;
    int errors = 0;
    int prog   = 0;
    logic [31:0] seed = 32'h1234_5678;

    // R2 opcode values
    localparam logic [5:0] T_J = 6'h02, T_JL = 6'h03, T_BZ = 6'h04,
                           T_BNZ = 6'h05, T_JR = 6'h06, T_JRL = 6'h07;

    logic [31:0] m_pc, m_d, m_e;
    logic [31:0] hist[$];

    always #4 clk = ~clk;

    npc_kill_unit uut (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .stall(stall),
        .alu_zero(alu_zero), .jabs_target(jabs_target),
        .rind_target(rind_target), .br_target(br_target), .pc(pc),
        .ir_dec(ir_dec), .ir_exe(ir_exe), .pc_sel(pc_sel),
        .dec_sel(dec_sel), .exe_sel(exe_sel)
    );

    function automatic logic [31:0] plain(input logic [31:0] a);
        return {6'h08, a[25:0]};
    endfunction

    function automatic logic [31:0] word_at(input int p, input logic [31:0] a);
        logic [31:0] h;
        if (p == 0) begin
            if (a == 32'h04) return {T_J, 26'h1};
            if (a == 32'h20) return {T_BZ, 26'h2};
            if (a == 32'h24) return {T_JL, 26'h3};
            if (a == 32'h48) return {T_JR, 26'h4};
            return plain(a);
        end
        h = (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
        case (h[31:28])
            4'd0: return {T_J,   h[25:0]};
            4'd1: return {T_JL,  h[25:0]};
            4'd2: return {T_BZ,  h[25:0]};
            4'd3: return {T_BNZ, h[25:0]};
            4'd4: return {T_JR,  h[25:0]};
            4'd5: return {T_JRL, h[25:0]};
            4'd6: return 32'h0;
            default: return plain(a);
        endcase
    endfunction

    assign fetch_word = word_at(prog, pc);

    function automatic logic is_jump(input logic [31:0] w);
        return w[31:26] == T_J || w[31:26] == T_JL ||
               w[31:26] == T_JR || w[31:26] == T_JRL;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // one clock: drive at negedge, compare, then advance the model
    task automatic step(input logic st, input logic z);
        logic       taken;
        logic [1:0] esel;
        logic       ekd, eke;
        logic [31:0] npc, nd, ne;
        string      tg;
        stall = st;
        alu_zero = z;
        #1;
        chk("R6", "pc", pc, m_pc);
        chk("R7", "ir_dec", ir_dec, m_d);
        chk("R8", "ir_exe", ir_exe, m_e);
        hist.push_back(ir_exe);
        taken = (m_e[31:26] == T_BZ && z) || (m_e[31:26] == T_BNZ && !z);
        if (taken) begin esel = 2'd3; tg = "R3"; end
        else if (m_d[31:26] == T_J || m_d[31:26] == T_JL) begin esel = 2'd1; tg = "R4"; end
        else if (m_d[31:26] == T_JR || m_d[31:26] == T_JRL) begin esel = 2'd2; tg = "R5"; end
        else begin esel = 2'd0; tg = "R6"; end
        if (st && esel != 2'd0) tg = {tg, " R10"};
        chk({tg, " R2"}, "pc_sel", {30'h0, pc_sel}, {30'h0, esel});
        ekd = taken || is_jump(m_d);
        eke = taken || st;
        chk(st ? "R7 R10" : "R7", "dec_sel", {31'h0, dec_sel}, {31'h0, ekd});
        chk("R8", "exe_sel", {31'h0, exe_sel}, {31'h0, eke});
        case (esel)
            2'd3: npc = br_target;
            2'd1: npc = jabs_target;
            2'd2: npc = rind_target;
            default: npc = st ? m_pc : m_pc + 32'd4;
        endcase
        nd = ekd ? 32'h0 : (st ? m_d : word_at(prog, m_pc));
        ne = eke ? 32'h0 : m_d;
        @(posedge clk);
        m_pc = npc; m_d = nd; m_e = ne;
        @(negedge clk);
    endtask

    task automatic scan_bubbles(input logic z);
        for (int i = 0; i + 3 < hist.size(); i++) begin
            if (is_jump(hist[i])) begin
                chk("R9", "jump bubble", hist[i+1], 32'h0);
                chk("R9", "jump single", {31'h0, hist[i+2] != 0}, 32'h1);
            end else if (hist[i][31:26] == T_BZ) begin
                if (z) begin
                    chk("R9", "branch bubble1", hist[i+1], 32'h0);
                    chk("R9", "branch bubble2", hist[i+2], 32'h0);
                    chk("R9", "branch end", {31'h0, hist[i+3] != 0}, 32'h1);
                end else begin
                    chk("R9", "not-taken", {31'h0, hist[i+1] != 0}, 32'h1);
                end
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "pc in reset", pc, 32'h0);
        chk("R1", "ir_dec in reset", ir_dec, 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R1", "pc after reset", pc, 32'h0);
        chk("R1", "ir_dec after reset", ir_dec, 32'h0);
        chk("R1", "ir_exe after reset", ir_exe, 32'h0);
        m_pc = 32'h0; m_d = 32'h0; m_e = 32'h0;

        // directed loop, taken branch
        prog = 0;
        jabs_target = 32'h20; br_target = 32'h40; rind_target = 32'h04;
        hist.delete();
        repeat (60) step(1'b0, 1'b1);
        scan_bubbles(1'b1);

        // directed loop, branch not taken
        hist.delete();
        repeat (60) step(1'b0, 1'b0);
        scan_bubbles(1'b0);

        // pseudo-random program, stalls and flags
        prog = 1;
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = rnd();
            jabs_target = {22'h0, r[9:2], 2'b00};
            rind_target = {22'h0, r[17:10], 2'b00};
            br_target   = {22'h0, r[25:18], 2'b00};
            step(r[27:26] == 2'b00, r[28]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule